// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a flat panel. Four 32-bit words go in through a small write port: a horizontal timing word, a vertical timing word, a polarity word and a control word. Once the generator is enabled, a pair of counters sweeps every line and every frame. They drive horizontal sync, vertical sync and data enable, a static pixel-clock edge selector, the current pixel and line position, and a one-cycle pulse at the start of each frame.

Writes land in a shadow set of registers. While the generator runs, the counters use a working copy, and that copy is refreshed only when a frame wraps. While the generator is stopped, the working copy follows the shadow set on every cycle, so the next run starts with the values just written. Each line runs through its visible pixels, then its front porch, then the sync pulse, then its back porch. A frame runs through its lines in the same order. The line position counts 0 to total-1 across all four intervals, and so does the pixel position.

Top module: `lcd_raster_gen`

## Requirements
- R1: The horizontal word (write select 0) sets the visible pixels to (bits 7:2 + 1) x 16, the front porch to bits 23:16 + 1 clocks, the sync to bits 15:8 + 1 clocks and the back porch to bits 31:24 + 1 clocks, in the order visible, front porch, sync, back porch.
- R2: The vertical word (write select 1) sets the visible lines to bits 9:0 + 1 and the sync to bits 15:10 + 1 lines. Bits 23:16 give the front porch lines and bits 31:24 the back porch lines, both as raw counts. A frame lasts (pixels per line) x (lines per frame) clocks.
- R3: A vertical porch value of zero gives a porch of zero lines.
- R4: Setting control bit 7 (dual-panel) does not change the count of visible lines. The lines field alone sets it.
- R5: The polarity word (write select 2) inverts vsync with bit 11, hsync with bit 12 and data enable with bit 14. Bit 13 appears unchanged on `pclk_edge`.
- R6: While control bit 0 (write select 3) is clear, hsync, vsync and data enable sit at their inactive levels and `frame_start` stays low. The position counters are zero from the next cycle on.
- R7: `depth_code` carries control bits 3:1 of the working copy unchanged.
- R8: `frame_start` is high for exactly one cycle, when the position is pixel 0 of line 0 while the generator runs.
- R9: While the generator runs, a write changes the working timing only at a frame wrap, so a frame never mixes old and new values.
- R10: `px_x` advances by one per clock through the whole line and returns to 0 after the last back-porch clock. `ln_y` advances at each line wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Word select: 0 horizontal, 1 vertical, 2 polarity, 3 control |
| wr_data | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pclk_edge | output | 1 | Pixel clock edge select |
| frame_start | output | 1 | One-cycle pulse at pixel 0 of line 0 |
| px_x | output | HW | Pixel position within the line |
| ln_y | output | VW | Line position within the frame |
| depth_code | output | 3 | Pixel depth code, 0..5 |

## Verification
The hardest case to reach from the ports is a timing write that lands in the middle of a running frame. The old frame must finish on its old timing, and the new values must apply from the very next frame. The stimulus rewrites the horizontal word partway through the third frame of a run. A cycle-by-cycle predictor, kept outside the design, swaps its own working copy only at its own frame wrap. The measured gap between later frame pulses must then match the new line length. A second run stops the generator, reprograms polarity and uses zero-line porches with dual-panel set, then restarts. This checks the inverted idle levels and the raw porch counts.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    // write port word selects
    localparam logic [1:0] SEL_HTIM = 2'd0;
    localparam logic [1:0] SEL_VTIM = 2'd1;
    localparam logic [1:0] SEL_POL  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    // polarity word bits
    localparam int P_VS_INV = 11;
    localparam int P_HS_INV = 12;
    localparam int P_EDGE   = 13;
    localparam int P_DE_INV = 14;

    // control word bits
    localparam int C_RUN = 0;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] pol;
        logic [31:0] vtim;
        logic [31:0] htim;
    } tg_words_t;

endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        frame_wrap,
    output tg_words_t   shadow_o,
    output tg_words_t   working_o
);

    typedef struct packed {
        tg_words_t sh;
        tg_words_t wk;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // stopped: follow shadow; running: refresh only on frame wrap
        if (!st_q.sh.ctrl[C_RUN] || frame_wrap) begin
            st_d.wk = st_q.sh;
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_HTIM: st_d.sh.htim = wr_data;
                SEL_VTIM: st_d.sh.vtim = wr_data;
                SEL_POL:  st_d.sh.pol  = wr_data;
                default:  st_d.sh.ctrl = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o  = st_q.sh;
    assign working_o = st_q.wk;

endmodule

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic [31:0]   htim,
    input  logic [31:0]   vtim,
    output logic [HW-1:0] h_act,
    output logic [HW-1:0] h_sync_lo,
    output logic [HW-1:0] h_sync_hi,
    output logic [HW-1:0] h_last,
    output logic [VW-1:0] v_act,
    output logic [VW-1:0] v_sync_lo,
    output logic [VW-1:0] v_sync_hi,
    output logic [VW-1:0] v_last
);

    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [HW-1:0] H_BLK = HW'(16);
    localparam logic [VW-1:0] V_ONE = VW'(1);

    logic unused_lsb;
    assign unused_lsb = ^htim[1:0];

    always_comb begin
        // horizontal: all intervals stored minus one, width in blocks of 16
        h_act     = (HW'(htim[7:2]) << 4) + H_BLK;
        h_sync_lo = h_act     + HW'(htim[23:16]) + H_ONE;
        h_sync_hi = h_sync_lo + HW'(htim[15:8])  + H_ONE;
        h_last    = h_sync_hi + HW'(htim[31:24]);
        // vertical: lines and sync minus one, porches raw
        v_act     = VW'(vtim[9:0]) + V_ONE;
        v_sync_lo = v_act     + VW'(vtim[23:16]);
        v_sync_hi = v_sync_lo + VW'(vtim[15:10]) + V_ONE;
        v_last    = v_sync_hi + VW'(vtim[31:24]) - V_ONE;
    end

endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] h_last,
    input  logic [VW-1:0] v_last,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       h_end, v_end;

    always_comb begin
        st_d  = st_q;
        h_end = (st_q.h == h_last);
        v_end = (st_q.v == v_last);
        if (!run) begin
            st_d = '0;
        end else if (h_end) begin
            st_d.h = '0;
            st_d.v = v_end ? '0 : st_q.v + VW'(1);
        end else begin
            st_d.h = st_q.h + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_o    = st_q.h;
    assign v_o    = st_q.v;
    assign wrap_o = run && h_end && v_end;

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lcd_tg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pclk_edge,
    output logic          frame_start,
    output logic [HW-1:0] px_x,
    output logic [VW-1:0] ln_y,
    output logic [2:0]    depth_code
);

    tg_words_t     shadow, working;
    logic          run, frame_wrap;
    logic [HW-1:0] h_cnt, h_act, h_sync_lo, h_sync_hi, h_last;
    logic [VW-1:0] v_cnt, v_act, v_sync_lo, v_sync_hi, v_last;
    logic [31:0]   wk_h, wk_v;
    logic          unused_bits;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic fs;
    } raw_out_t;

    raw_out_t raw;

    assign run  = shadow.ctrl[C_RUN];
    assign wk_h = working.htim;
    assign wk_v = working.vtim;

    lcd_tg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .shadow_o   (shadow),
        .working_o  (working)
    );

    lcd_tg_decode #(.HW(HW), .VW(VW)) u_decode (
        .htim      (working.htim),
        .vtim      (working.vtim),
        .h_act     (h_act),
        .h_sync_lo (h_sync_lo),
        .h_sync_hi (h_sync_hi),
        .h_last    (h_last),
        .v_act     (v_act),
        .v_sync_lo (v_sync_lo),
        .v_sync_hi (v_sync_hi),
        .v_last    (v_last)
    );

    lcd_tg_counter #(.HW(HW), .VW(VW)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .h_last (h_last),
        .v_last (v_last),
        .h_o    (h_cnt),
        .v_o    (v_cnt),
        .wrap_o (frame_wrap)
    );

    // interval decode; all gated by run so a stop is seen at once
    always_comb begin
        raw.hs = run && (h_cnt >= h_sync_lo) && (h_cnt < h_sync_hi);
        raw.vs = run && (v_cnt >= v_sync_lo) && (v_cnt < v_sync_hi);
        raw.de = run && (h_cnt < h_act) && (v_cnt < v_act);
        raw.fs = run && (h_cnt == '0) && (v_cnt == '0);
    end

    assign hsync       = raw.hs ^ working.pol[P_HS_INV];
    assign vsync       = raw.vs ^ working.pol[P_VS_INV];
    assign de          = raw.de ^ working.pol[P_DE_INV];
    assign pclk_edge   = working.pol[P_EDGE];
    assign frame_start = raw.fs;
    assign px_x        = h_cnt;
    assign ln_y        = v_cnt;
    assign depth_code  = working.ctrl[3:1];

    assign unused_bits = ^{shadow.htim, shadow.vtim, shadow.pol, shadow.ctrl[31:1],
                           working.ctrl[31:4], working.ctrl[0],
                           working.pol[31:15], working.pol[10:0]};

endmodule

// File: rtl/lcd_raster_gen_chk.sv
module lcd_raster_gen_chk #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          wrap,
    input logic          frame_start,
    input logic [HW-1:0] px_x,
    input logic [VW-1:0] ln_y,
    input logic [31:0]   wk_h,
    input logic [31:0]   wk_v
);

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);  // R8

    AST_FS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (px_x == '0 && ln_y == '0));  // R8

    AST_IDLE_NO_FS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !frame_start);  // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (px_x == '0 && ln_y == '0));  // R6

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (px_x != '0) |-> (px_x == $past(px_x) + HW'(1)));  // R10

    AST_WORK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(wrap)) |-> ($stable(wk_h) && $stable(wk_v)));  // R9

endmodule

bind lcd_raster_gen lcd_raster_gen_chk #(.HW(HW), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .wrap        (frame_wrap),
    .frame_start (frame_start),
    .px_x        (px_x),
    .ln_y        (ln_y),
    .wk_h        (wk_h),
    .wk_v        (wk_v)
);

// File: tb/lcd_raster_gen_tb.sv
module lcd_raster_gen_tb;

    localparam int HW = 12;
    localparam int VW = 11;

    // phase A: 16 px, fp 3, sync 2, bp 4 -> 25; 3 lines, vfp 1, vs 2, vbp 2 -> 8
    localparam logic [31:0] H1 = {8'd3, 8'd2, 8'd1, 6'd0, 2'b00};
    localparam logic [31:0] V1 = {8'd2, 8'd1, 6'd1, 10'd2};
    // phase B: 32 px, fp 1, sync 3, bp 2 -> 38
    localparam logic [31:0] H2 = {8'd1, 8'd0, 8'd2, 6'd1, 2'b00};
    // phase C: 4 lines, vfp 0, vs 1, vbp 1 -> 6
    localparam logic [31:0] V2 = {8'd1, 8'd0, 6'd0, 10'd3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [31:0]   wr_data = 32'd0;
    logic          hsync, vsync, de, pclk_edge, frame_start;
    logic [HW-1:0] px_x;
    logic [VW-1:0] ln_y;
    logic [2:0]    depth_code;

    always #5 clk = ~clk;

    lcd_raster_gen #(.HW(HW), .VW(VW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .pclk_edge   (pclk_edge),
        .frame_start (frame_start),
        .px_x        (px_x),
        .ln_y        (ln_y),
        .depth_code  (depth_code)
    );

    typedef struct {
        int hs, vs, de, fs, edge_sel, x, y, dep;
        string tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          fs_at[$];
    string       cur_tag = "R6";
    logic [31:0] sh[4];
    logic [31:0] wk[4];
    int          mh = 0;
    int          mv = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int line_len(logic [31:0] w);
        return (int'(w[7:2]) + 1) * 16 + int'(w[23:16]) + 1 + int'(w[15:8]) + 1 + int'(w[31:24]) + 1;
    endfunction

    function automatic int frame_lines(logic [31:0] w);
        return int'(w[9:0]) + 1 + int'(w[23:16]) + int'(w[15:10]) + 1 + int'(w[31:24]);
    endfunction

    function automatic exp_t predict();
        exp_t e;
        int   vis, hs_a, hs_b, vl, vs_a, vs_b;
        bit   on;
        on   = sh[3][0];
        vis  = (int'(wk[0][7:2]) + 1) * 16;
        hs_a = vis + int'(wk[0][23:16]) + 1;
        hs_b = hs_a + int'(wk[0][15:8]) + 1;
        vl   = int'(wk[1][9:0]) + 1;
        vs_a = vl + int'(wk[1][23:16]);
        vs_b = vs_a + int'(wk[1][15:10]) + 1;
        e.hs = int'((on && mh >= hs_a && mh < hs_b) ^ wk[2][12]);
        e.vs = int'((on && mv >= vs_a && mv < vs_b) ^ wk[2][11]);
        e.de = int'((on && mh < vis && mv < vl) ^ wk[2][14]);
        e.fs = int'(on && mh == 0 && mv == 0);
        e.edge_sel = int'(wk[2][13]);
        e.x   = mh;
        e.y   = mv;
        e.dep = int'(wk[3][3:1]);
        e.tag = cur_tag;
        return e;
    endfunction

    // predictor: pushes the expected output state for each new cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                sh[i] = '0;
                wk[i] = '0;
            end
            mh = 0;
            mv = 0;
        end else begin
            if (!sh[3][0]) begin
                wk = sh;
                mh = 0;
                mv = 0;
            end else if (mh == line_len(wk[0]) - 1) begin
                mh = 0;
                if (mv == frame_lines(wk[1]) - 1) begin
                    mv = 0;
                    wk = sh;
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
            if (wr_en) sh[wr_sel] = wr_data;
            sb_q.push_back(predict());
        end
    end

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (frame_start) fs_at.push_back(cyc);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " hsync"}, int'(hsync), e.hs);
            chk({e.tag, " vsync"}, int'(vsync), e.vs);
            chk({e.tag, " de"}, int'(de), e.de);
            chk("R8 frame_start", int'(frame_start), e.fs);
            chk("R5 pclk_edge", int'(pclk_edge), e.edge_sel);
            chk("R10 px_x", int'(px_x), e.x);
            chk("R10 ln_y", int'(ln_y), e.y);
            chk("R7 depth_code", int'(depth_code), e.dep);
        end
    end

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_period(string tag, int exp);
        if (fs_at.size() < 2) chk({tag, " frame pulses seen"}, fs_at.size(), 2);
        else                  chk({tag, " frame period"}, fs_at[1] - fs_at[0], exp);
    endtask

    initial begin
        fork
            begin
                idle(3);
                // R6: reset state
                chk("R6 reset hsync", int'(hsync), 0);
                chk("R6 reset vsync", int'(vsync), 0);
                chk("R6 reset de", int'(de), 0);
                chk("R6 reset frame_start", int'(frame_start), 0);
                chk("R6 reset px_x", int'(px_x), 0);
                rst_n = 1'b1;

                cur_tag = "R1";
                wr(2'd0, H1);
                wr(2'd1, V1);
                wr(2'd2, 32'h0);
                wr(2'd3, 32'h6);
                idle(3);
                chk("R7 depth while stopped", int'(depth_code), 3);
                fs_at.delete();
                wr(2'd3, 32'h7);
                idle(450);
                chk_period("R2", 25 * 8);

                // R9: horizontal word rewritten mid-frame
                cur_tag = "R9";
                fs_at.delete();
                wr(2'd0, H2);
                idle(700);
                chk_period("R9", 38 * 8);

                // R5 R3 R4: stop, invert all, zero porch, dual set, depth 5
                cur_tag = "R5";
                wr(2'd3, 32'h8A);
                idle(5);
                wr(2'd2, 32'h0000_7800);
                wr(2'd1, V2);
                idle(3);
                chk("R5 idle hsync inverted", int'(hsync), 1);
                chk("R5 idle vsync inverted", int'(vsync), 1);
                chk("R5 idle de inverted", int'(de), 1);
                chk("R5 edge select", int'(pclk_edge), 1);
                chk("R7 depth code 5", int'(depth_code), 5);
                fs_at.delete();
                cur_tag = "R3";
                wr(2'd3, 32'h8B);
                idle(500);
                chk_period("R3 R4", 38 * 6);

                cur_tag = "R6";
                wr(2'd3, 32'h8A);
                idle(10);
                chk("R6 stopped px_x", int'(px_x), 0);
                chk("R6 stopped ln_y", int'(ln_y), 0);
                chk("R6 stopped hsync idle", int'(hsync), 1);
                chk("R6 stopped frame_start", int'(frame_start), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: all requirements actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule